// File: doc/BRIEF.md
# Oscillation Stabilization Wait Counter

This block runs in the crystal oscillator's own clock domain and measures how long the oscillator has been running since it was last started or since the chip last woke from stop mode. A saturating up-counter counts oscillator cycles. Its value is reported as an 8-bit read-only status byte that fills like a thermometer: each time one of eight unevenly spaced elapsed-time thresholds is crossed, one more bit is set, starting from bit 7 and moving down. A separate flag reports that the wait time picked by a 3-bit select code has elapsed.

Software polls the status byte, either whole or one bit at a time through a bit-index input, to decide when the oscillator is settled enough to be used. Clearing happens on reset, on stop-mode entry and while the oscillator-stop control is held high. Counting is restarted by releasing the stop control or by leaving stop mode. The counter never goes past the selected wait time, so thresholds above the selected one are never reported.

The control is a five-state machine. HALT is entered on reset and whenever `osc_stop` is high. SLEEP is entered on a `stop_enter` pulse. RESUME is entered when `stop_enter` and `stop_exit` arrive in the same cycle. COUNT is the active counting state. DONE is the saturated end state.

The transitions, in priority order:
- Any state goes to HALT when `osc_stop` is high.
- Otherwise, any state goes to SLEEP on `stop_enter` alone, or to RESUME on `stop_enter` together with `stop_exit`.
- Otherwise, HALT goes to COUNT, which is the oscillator start.
- SLEEP goes to COUNT on `stop_exit` and stays in SLEEP otherwise.
- RESUME always goes to COUNT.
- COUNT goes to DONE when the count reaches the selected threshold and stays in COUNT otherwise.
- DONE stays in DONE.

Top module: `osc_settle_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released with `osc_stop` high, `status` is 00h and `stabilized` is 0.
- R2: The threshold for tap k (k = 0..7) is 2^E[k] + 16 oscillator cycles, where E defaults to 8, 9, 10, 11, 13, 15, 17, 18. Tap k drives `status` bit 7−k, so the only reachable patterns are 00h, 80h, C0h, E0h, F0h, F8h, FCh, FEh and FFh. The count is 0 in the first cycle after a start, and it is 1 more in each later cycle.
- R3: While no clearing event occurs, no `status` bit that is 1 ever returns to 0.
- R4: One clock edge after `osc_stop` is sampled high or `stop_enter` is sampled high, `status` is 00h and `stabilized` is 0. Both stay that way while `osc_stop` is held high or while the block waits in stop mode.
- R5: Counting begins from 0 when `osc_stop` is low in HALT, which is the oscillator start. It also begins from 0 when a `stop_exit` pulse arrives during stop mode.
- R6: The count stops at the threshold of the tap chosen by `wait_sel`, where code 0 picks tap 0 and code 7 picks tap 7. Status bits for taps above the chosen one are never set.
- R7: `stabilized` rises in the same cycle as the status bit of the chosen tap. It stays high until a clearing event.
- R8: `wait_sel` is sampled only when counting begins. A change while counting has no effect on the final pattern.
- R9: When `stop_enter` and `stop_exit` are high in the same cycle, the clear takes effect first. Counting then begins one cycle later, so in the cycle after the pulse the count is still held at 0.
- R10: `rd_bit` equals `status` bit `rd_idx` for every index 0..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_stop | input | 1 | Oscillator-stop control; high clears and holds, falling starts counting |
| stop_enter | input | 1 | One-cycle pulse: stop mode entered |
| stop_exit | input | 1 | One-cycle pulse: stop mode released |
| wait_sel | input | 3 | Selected wait tap, 0 (shortest) to 7 (longest) |
| rd_idx | input | 3 | Bit index for single-bit status read |
| status | output | 8 | Thermometer status byte |
| rd_bit | output | 1 | Status bit selected by rd_idx |
| stabilized | output | 1 | Selected wait time has elapsed |

## Verification
The bench compares the status byte in every cycle of a full count against a model of the thresholds. An off-by-one in the count origin or a comparison using > instead of >= shows up at exactly one threshold edge. Runs with a small select code and with the select code changed mid-count would expose a counter that does not saturate or a select that is not latched: extra low bits would appear, or the flag would move. A stop-mode entry coinciding with a stop-mode exit checks that the clear wins and that counting starts one cycle late. A design that ignored the exit would stay cleared, and one that let the exit win would run a cycle early.

// File: rtl/ost_pkg.sv
package ost_pkg;

    localparam int NUM_TAPS = 8;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_SLEEP,
        ST_RESUME,
        ST_COUNT,
        ST_DONE
    } ost_state_e;

    // Largest exponent among the taps; sets the counter width.
    function automatic int unsigned tap_max(input logic [NUM_TAPS-1:0][4:0] e);
        int unsigned m;
        m = 0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            if (32'(e[i]) > m) m = 32'(e[i]);
        end
        return m;
    endfunction

    // Threshold of tap k in oscillator cycles.
    function automatic logic [31:0] tap_thr(input logic [NUM_TAPS-1:0][4:0] e,
                                            input int unsigned off,
                                            input int unsigned k);
        return (32'd1 << e[k]) + off;
    endfunction

endpackage

// File: rtl/ost_ctrl.sv
module ost_ctrl
    import ost_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_stop,
    input  logic       stop_enter,
    input  logic       stop_exit,
    input  logic [2:0] wait_sel,
    input  logic       at_lim,
    output logic [2:0] sel_q,
    output logic       cnt_clr,
    output logic       cnt_run,
    output logic       running
);

    ost_state_e state_q, state_d;
    logic       clear_evt;
    logic       start_evt;

    assign clear_evt = osc_stop | stop_enter;
    assign start_evt = (state_d == ST_COUNT) && (state_q != ST_COUNT);

    // Next-state logic: clearing events take priority over everything.
    always_comb begin
        state_d = state_q;
        if (osc_stop) begin
            state_d = ST_HALT;
        end else if (stop_enter) begin
            state_d = stop_exit ? ST_RESUME : ST_SLEEP;
        end else begin
            unique case (state_q)
                ST_HALT:   state_d = ST_COUNT;
                ST_SLEEP:  state_d = stop_exit ? ST_COUNT : ST_SLEEP;
                ST_RESUME: state_d = ST_COUNT;
                ST_COUNT:  state_d = at_lim ? ST_DONE : ST_COUNT;
                ST_DONE:   state_d = ST_DONE;
                default:   state_d = ST_HALT;
            endcase
        end
    end

    // State register, with the select code captured at each start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_evt) sel_q <= wait_sel;
        end
    end

    // Outputs.
    always_comb begin
        running = 1'b0;
        cnt_run = 1'b0;
        unique case (state_q)
            ST_COUNT: begin
                running = 1'b1;
                cnt_run = 1'b1;
            end
            ST_DONE:  running = 1'b1;
            default:  ;
        endcase
        cnt_clr = clear_evt | ~running;
    end

endmodule

// File: rtl/ost_count.sv
module ost_count
    import ost_pkg::*;
#(
    parameter logic [NUM_TAPS-1:0][4:0] TAP_EXP    = {5'd18, 5'd17, 5'd15, 5'd13,
                                                       5'd11, 5'd10, 5'd9,  5'd8},
    parameter int unsigned              TAP_OFFSET = 16,
    parameter int unsigned              CW         = tap_max(TAP_EXP) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [2:0]    sel_q,
    output logic [CW-1:0] cnt,
    output logic          at_lim
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim    = CW'(tap_thr(TAP_EXP, TAP_OFFSET, 32'(sel_q)));
        at_lim = (cnt_q == lim);
    end

    // Saturating up-counter: holds once the selected limit is reached.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && !at_lim) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/ost_thermo.sv
module ost_thermo
    import ost_pkg::*;
#(
    parameter logic [NUM_TAPS-1:0][4:0] TAP_EXP    = {5'd18, 5'd17, 5'd15, 5'd13,
                                                       5'd11, 5'd10, 5'd9,  5'd8},
    parameter int unsigned              TAP_OFFSET = 16,
    parameter int unsigned              CW         = tap_max(TAP_EXP) + 1
) (
    input  logic [CW-1:0]       cnt,
    input  logic                running,
    input  logic [2:0]          rd_idx,
    output logic [NUM_TAPS-1:0] status,
    output logic                rd_bit
);

    // One comparator per tap; tap k drives bit NUM_TAPS-1-k.
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        localparam logic [CW-1:0] THR = CW'(tap_thr(TAP_EXP, TAP_OFFSET, k));
        assign status[NUM_TAPS-1-k] = running && (cnt >= THR);
    end

    assign rd_bit = status[rd_idx];

endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer
    import ost_pkg::*;
#(
    parameter logic [NUM_TAPS-1:0][4:0] TAP_EXP    = {5'd18, 5'd17, 5'd15, 5'd13,
                                                       5'd11, 5'd10, 5'd9,  5'd8},
    parameter int unsigned              TAP_OFFSET = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_stop,
    input  logic       stop_enter,
    input  logic       stop_exit,
    input  logic [2:0] wait_sel,
    input  logic [2:0] rd_idx,
    output logic [7:0] status,
    output logic       rd_bit,
    output logic       stabilized
);

    localparam int unsigned CW = tap_max(TAP_EXP) + 1;

    logic [2:0]    sel_q;
    logic          cnt_clr;
    logic          cnt_run;
    logic          running;
    logic          at_lim;
    logic [CW-1:0] cnt;

    ost_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_stop   (osc_stop),
        .stop_enter (stop_enter),
        .stop_exit  (stop_exit),
        .wait_sel   (wait_sel),
        .at_lim     (at_lim),
        .sel_q      (sel_q),
        .cnt_clr    (cnt_clr),
        .cnt_run    (cnt_run),
        .running    (running)
    );

    ost_count #(
        .TAP_EXP    (TAP_EXP),
        .TAP_OFFSET (TAP_OFFSET),
        .CW         (CW)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .run    (cnt_run),
        .sel_q  (sel_q),
        .cnt    (cnt),
        .at_lim (at_lim)
    );

    ost_thermo #(
        .TAP_EXP    (TAP_EXP),
        .TAP_OFFSET (TAP_OFFSET),
        .CW         (CW)
    ) u_thermo (
        .cnt     (cnt),
        .running (running),
        .rd_idx  (rd_idx),
        .status  (status),
        .rd_bit  (rd_bit)
    );

    assign stabilized = running & at_lim;

endmodule

// File: rtl/ost_chk.sv
module ost_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_stop,
    input logic       stop_enter,
    input logic [7:0] status,
    input logic       stabilized
);

    logic [7:0] inv_status;
    assign inv_status = ~status;

    AST_THERMO_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_status & (inv_status + 8'd1)) == 8'd0); // R2

    AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_stop && !stop_enter) |=> ((status & $past(status)) == $past(status))); // R3

    AST_CLEAR_STOPCTL: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop |=> (status == 8'h00 && !stabilized)); // R4

    AST_CLEAR_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_enter |=> (status == 8'h00 && !stabilized)); // R4

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stabilized && !osc_stop && !stop_enter) |=> stabilized); // R7

    AST_FLAG_HAS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        stabilized |-> status[7]); // R7

endmodule

bind osc_settle_timer ost_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_stop   (osc_stop),
    .stop_enter (stop_enter),
    .status     (status),
    .stabilized (stabilized)
);

// File: tb/sim_osc_settle_timer.sv
module sim_osc_settle_timer;

    localparam int HALF_NS = 10; // 50 MHz
    localparam logic [7:0][4:0] B_EXP = {5'd10, 5'd9, 5'd8, 5'd7,
                                         5'd6,  5'd5, 5'd4, 5'd3};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_stop = 1'b1;
    logic       stop_enter = 1'b0;
    logic       stop_exit = 1'b0;
    logic [2:0] wait_sel = 3'd0;
    logic [2:0] rd_idx = 3'd0;
    logic [7:0] status;
    logic       rd_bit;
    logic       stabilized;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(HALF_NS) clk = ~clk;

    osc_settle_timer #(.TAP_EXP(B_EXP), .TAP_OFFSET(16)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_stop   (osc_stop),
        .stop_enter (stop_enter),
        .stop_exit  (stop_exit),
        .wait_sel   (wait_sel),
        .rd_idx     (rd_idx),
        .status     (status),
        .rd_bit     (rd_bit),
        .stabilized (stabilized)
    );

    function automatic int thr(input int k);
        return (1 << B_EXP[k]) + 16;
    endfunction

    function automatic logic [7:0] exp_status(input int c, input int sel);
        logic [7:0] s;
        s = 8'h00;
        for (int k = 0; k < 8; k++)
            if (k <= sel && c >= thr(k)) s[7-k] = 1'b1;
        return s;
    endfunction

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: status actual %02h expected %02h", req, act, expv);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: bit actual %0b expected %0b", req, act, expv);
        end
    endtask

    // Runs n cycles after a start stimulus driven at the preceding negedge.
    // After posedge j the count is j-off (clamped at 0), saturating at the tap limit.
    task automatic run_window(input int sel, input int off, input int n, input string req);
        for (int j = 1; j <= n; j++) begin
            int c;
            @(posedge clk);
            @(negedge clk);
            stop_enter = 1'b0;
            stop_exit  = 1'b0;
            c = (j - off < 0) ? 0 : j - off;
            if (c > thr(sel)) c = thr(sel);
            chk8(req, status, exp_status(c, sel));
            chk1({req, " stabilized"}, stabilized, c >= thr(sel));
        end
    endtask

    task automatic hold_osc_stop(input int n);
        @(negedge clk);
        osc_stop = 1'b1;
        for (int j = 0; j < n; j++) begin
            @(posedge clk);
            @(negedge clk);
            chk8("R4 osc_stop clear", status, 8'h00);
            chk1("R4 osc_stop flag", stabilized, 1'b0);
        end
    endtask

    task automatic start_osc(input int sel);
        wait_sel = 3'(sel);
        osc_stop = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk8("R1 in reset", status, 8'h00);
        chk1("R1 in reset flag", stabilized, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk8("R1 after release", status, 8'h00);
        chk1("R1 after release flag", stabilized, 1'b0);
    endtask

    task automatic t_full_sweep;
        // R2 R3 R5 R7: every threshold edge of all eight taps, then saturation.
        start_osc(7);
        run_window(7, 1, thr(7) + 30, "R2 full sweep");
        hold_osc_stop(3);
    endtask

    task automatic t_limited;
        // R6: select 2 stops at tap 2; lower bits never appear.
        start_osc(2);
        run_window(2, 1, 200, "R6 limited tap2");
        chk8("R6 final pattern", status, 8'hE0);
        hold_osc_stop(2);
    endtask

    task automatic t_sel_change;
        // R8: select changed mid-count is ignored.
        start_osc(1);
        run_window(1, 1, 5, "R8 before change");
        wait_sel = 3'd7;
        run_window(1, 6 - 5, 0, "R8 noop");
        for (int j = 6; j <= 120; j++) begin
            int c;
            @(posedge clk);
            @(negedge clk);
            c = j - 1;
            if (c > thr(1)) c = thr(1);
            chk8("R8 after change", status, exp_status(c, 1));
        end
        chk1("R8 stabilized", stabilized, 1'b1);
        hold_osc_stop(2);
    endtask

    task automatic t_sleep;
        // R4 R5: stop-mode entry clears, exit restarts from zero.
        start_osc(7);
        run_window(7, 1, 60, "R5 pre-sleep");
        stop_enter = 1'b1;
        for (int j = 0; j < 10; j++) begin
            @(posedge clk);
            @(negedge clk);
            stop_enter = 1'b0;
            chk8("R4 sleep clear", status, 8'h00);
            chk1("R4 sleep flag", stabilized, 1'b0);
        end
        wait_sel  = 3'd3;
        stop_exit = 1'b1;
        run_window(3, 1, 100, "R5 wake restart");
    endtask

    task automatic t_collide;
        // R9: enter and exit together; clear wins, counting one cycle late.
        @(negedge clk);
        wait_sel   = 3'd4;
        stop_enter = 1'b1;
        stop_exit  = 1'b1;
        run_window(4, 2, 170, "R9 collide");
    endtask

    task automatic t_rdbit;
        // R10: single-bit read of the F8h pattern left by t_collide.
        chk8("R10 base pattern", status, 8'hF8);
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #1;
            chk1("R10 rd_bit", rd_bit, status[i]);
            chk1("R10 rd_bit value", rd_bit, (8'hF8 >> i) & 1);
        end
        hold_osc_stop(2);
    endtask

    task automatic t_sel0;
        // R7: shortest tap; flag sticks through a long idle stretch.
        start_osc(0);
        run_window(0, 1, 200, "R7 tap0 flag");
        chk8("R7 tap0 pattern", status, 8'h80);
        hold_osc_stop(2);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(2 * HALF_NS * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_full_sweep();
        t_limited();
        t_sel_change();
        t_sleep();
        t_collide();
        t_rdbit();
        t_sel0();
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule